// File: doc/BRIEF.md
# Escalating Four-Stage Watchdog

This block supervises software by counting prescaled clock ticks through four timeout stages in a fixed order. Each stage has its own hold time (a tick count) and its own action: do nothing, raise an interrupt, pulse a CPU reset, or pulse a system reset. When a stage's hold time runs out, the block performs that stage's action and moves on to the next stage. After the last stage it starts again at the first. Software that is still alive writes the feed register, which sends the sequence back to the start of stage 0.

Configuration sits behind a write key. While the key register holds the unlock value, configuration writes are accepted. Any other value in the key register blocks them. Newly written control fields and hold times are staged first. They take effect only when a control write sets the apply bit. The interrupt is held in a raw status bit until software clears it, and it is masked by an enable bit. The two reset outputs are pulses whose width is selected by a 3-bit code and counted in input clocks.

The state machine has five states:
- ST_IDLE: disabled.
- ST_STAGE0 to ST_STAGE3: counting in that stage.

Its transitions are:
- enable-off: any state goes to ST_IDLE.
- start: ST_IDLE goes to ST_STAGE0.
- feed: any enabled state goes to ST_STAGE0.
- expire: a stage goes to the following stage.
- wrap: ST_STAGE3 goes to ST_STAGE0.
- hold: the state is kept.

Top module: `esc_watchdog`

## Requirements
- R1: After reset, the register reads return the following values:
  - control: 0x0000_1200. The block is disabled, every action is 0, and both length codes are 1.
  - hold 0 to 3: 26000000, 0x7FFFFFF, 0xFFFFF and 0xFFFFF.
  - prescaler: 1.
  - key: 0x50D83AA1.

  The irq_o, cpu_rst_o and sys_rst_o outputs are all 0.
- R2: Writes to addresses 0 to 6 (control, prescaler, the four holds and feed) are ignored unless the key register (address 7) holds 0x50D83AA1. The key register is always writable.
- R3: The control register is at address 0. Its fields are:
  - [0] enable.
  - [2:1], [4:3], [6:5] and [8:7]: the actions of stages 0 to 3.
  - [11:9] CPU-reset length code.
  - [14:12] system-reset length code.
  - [15] apply.

  Control fields and holds (addresses 2 to 5) take effect only on a control write with bit 15 set. Until then, no counting and no action happen. Reads return the staged fields, with bit 15 read as 0.
- R4: The prescaler is at address 1, with bits [15:0] as the divisor; 0 acts as 1. A tick occurs once every divisor clocks. A stage expires on its hold-th tick, and a hold of 0 acts as 1. For a stage-0 interrupt, the raw bit is set on the edge hold*divisor cycles after the enabling write's edge.
- R5: Action codes are 0 = none, 1 = set the interrupt raw bit, 2 = CPU-reset pulse, 3 = system-reset pulse. Stages run in the order 0, 1, 2, 3.
- R6: After stage 3 expires, counting resumes in stage 0 and the sequence repeats.
- R7: Any write to address 6 (feed) while enabled restarts stage 0 with a zero tick count and clears the prescaler count.
- R8: A reset pulse goes high the cycle after the expiring edge. It lasts units*CLKS_PER_UNIT clocks, where units is 1, 2, 3, 4, 5, 8, 16 or 32 for codes 0 to 7.
- R9: Writing prescaler bit 31 as 1 clears the prescaler count.
- R10: The interrupt raw bit (address 9, bit 0) is cleared by writing 1 to that bit, and writing 0 leaves it set. A new set wins over a clear. irq_o is the raw bit ANDed with the interrupt enable (address 8, bit 0). Address 10 reads this masked status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Masked interrupt request |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
The bench builds the block with CLKS_PER_UNIT = 2 and the default 32-bit hold and 16-bit divisor widths. The short unit makes the full pulse-length mapping and retriggering observable within a few dozen cycles. Small hold values written through the unlocked interface let the bench see a complete four-stage escalation and its wrap in about twenty cycles. Divisors of 3 and 4 place the prescaler timing and its clear on exact, countable edges.

// File: rtl/esc_wdog_pkg.sv
package esc_wdog_pkg;

    localparam int NUM_STAGES = 4;
    localparam logic [31:0] UNLOCK_KEY = 32'h50D8_3AA1;

    localparam logic [3:0] A_CTRL    = 4'd0;
    localparam logic [3:0] A_PRESC   = 4'd1;
    localparam logic [3:0] A_HOLD0   = 4'd2;
    localparam logic [3:0] A_FEED    = 4'd6;
    localparam logic [3:0] A_KEY     = 4'd7;
    localparam logic [3:0] A_IRQ_EN  = 4'd8;
    localparam logic [3:0] A_IRQ_RAW = 4'd9;
    localparam logic [3:0] A_IRQ_ST  = 4'd10;

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_IRQ     = 2'd1,
        ACT_CPU_RST = 2'd2,
        ACT_SYS_RST = 2'd3
    } act_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAGE0,
        ST_STAGE1,
        ST_STAGE2,
        ST_STAGE3
    } stage_e;

    typedef struct packed {
        logic                        en;
        logic [NUM_STAGES-1:0][1:0]  act;
        logic [2:0]                  cpu_len;
        logic [2:0]                  sys_len;
    } wdog_cfg_t;

    localparam wdog_cfg_t CFG_RESET = '{en: 1'b0, act: '0, cpu_len: 3'd1, sys_len: 3'd1};

    function automatic wdog_cfg_t unpack_ctrl(input logic [31:0] w);
        wdog_cfg_t c;
        c.en = w[0];
        for (int s = 0; s < NUM_STAGES; s++) begin
            c.act[s] = w[1+2*s +: 2];
        end
        c.cpu_len = w[11:9];
        c.sys_len = w[14:12];
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input wdog_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[0] = c.en;
        for (int s = 0; s < NUM_STAGES; s++) begin
            w[1+2*s +: 2] = c.act[s];
        end
        w[11:9]  = c.cpu_len;
        w[14:12] = c.sys_len;
        return w;
    endfunction

    function automatic logic [5:0] len_units(input logic [2:0] code);
        logic [5:0] u;
        case (code)
            3'd0:    u = 6'd1;
            3'd1:    u = 6'd2;
            3'd2:    u = 6'd3;
            3'd3:    u = 6'd4;
            3'd4:    u = 6'd5;
            3'd5:    u = 6'd8;
            3'd6:    u = 6'd16;
            default: u = 6'd32;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/esc_wdog_regs.sv
module esc_wdog_regs
    import esc_wdog_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int DIV_W = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [3:0]                        wr_addr,
    input  logic [31:0]                       wr_data,
    input  logic [3:0]                        rd_addr,
    output logic [31:0]                       rd_data,
    input  logic                              irq_set,
    output wdog_cfg_t                         act_cfg,
    output logic [NUM_STAGES-1:0][CNT_W-1:0]  act_hold,
    output logic [DIV_W-1:0]                  div,
    output logic                              presc_clr,
    output logic                              feed,
    output logic                              int_raw,
    output logic                              int_ena
);

    localparam logic [CNT_W-1:0] HOLD0_RST = CNT_W'(26000000);
    localparam logic [CNT_W-1:0] HOLD1_RST = CNT_W'(32'h07FF_FFFF);
    localparam logic [CNT_W-1:0] HOLD23_RST = CNT_W'(32'h000F_FFFF);

    wdog_cfg_t                        sh_cfg;
    logic [NUM_STAGES-1:0][CNT_W-1:0] sh_hold;
    logic [31:0]                      key_q;
    logic                             unlocked;
    logic                             prot_wr;

    assign unlocked  = (key_q == UNLOCK_KEY);
    assign prot_wr   = wr_en && unlocked;
    assign presc_clr = prot_wr && (wr_addr == A_PRESC) && wr_data[31];
    assign feed      = prot_wr && (wr_addr == A_FEED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q    <= UNLOCK_KEY;
            sh_cfg   <= CFG_RESET;
            act_cfg  <= CFG_RESET;
            div      <= DIV_W'(1);
            sh_hold  <= {HOLD23_RST, HOLD23_RST, HOLD1_RST, HOLD0_RST};
            act_hold <= {HOLD23_RST, HOLD23_RST, HOLD1_RST, HOLD0_RST};
            int_ena  <= 1'b0;
            int_raw  <= 1'b0;
        end else begin
            if (wr_en && wr_addr == A_KEY) begin
                key_q <= wr_data;
            end
            if (prot_wr && wr_addr == A_CTRL) begin
                sh_cfg <= unpack_ctrl(wr_data);
                if (wr_data[15]) begin
                    act_cfg  <= unpack_ctrl(wr_data);
                    act_hold <= sh_hold;
                end
            end
            if (prot_wr && wr_addr == A_PRESC) begin
                div <= wr_data[DIV_W-1:0];
            end
            for (int s = 0; s < NUM_STAGES; s++) begin
                if (prot_wr && wr_addr == (A_HOLD0 + 4'(s))) begin
                    sh_hold[s] <= wr_data[CNT_W-1:0];
                end
            end
            if (wr_en && wr_addr == A_IRQ_EN) begin
                int_ena <= wr_data[0];
            end
            if (irq_set) begin
                int_raw <= 1'b1;
            end else if (wr_en && wr_addr == A_IRQ_RAW && wr_data[0]) begin
                int_raw <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:    rd_data = pack_ctrl(sh_cfg);
            A_PRESC:   rd_data = 32'(div);
            A_KEY:     rd_data = key_q;
            A_IRQ_EN:  rd_data = {31'd0, int_ena};
            A_IRQ_RAW: rd_data = {31'd0, int_raw};
            A_IRQ_ST:  rd_data = {31'd0, int_raw & int_ena};
            default:   rd_data = '0;
        endcase
        for (int s = 0; s < NUM_STAGES; s++) begin
            if (rd_addr == (A_HOLD0 + 4'(s))) begin
                rd_data = 32'(sh_hold[s]);
            end
        end
    end

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !unlocked && wr_addr == A_HOLD0 |=> $stable(sh_hold[0])); // R2
    AST_APPLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
        prot_wr && wr_addr == A_CTRL && wr_data[15] |=> act_cfg.en == $past(wr_data[0])); // R3
    AST_RAW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == A_IRQ_RAW && wr_data[0] && !irq_set |=> !int_raw); // R10

endmodule

// File: rtl/esc_wdog_prescaler.sv
module esc_wdog_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] count_q;
    logic [DIV_W-1:0] last;

    assign last = (div == '0) ? '0 : div - 1'b1;
    assign tick = run && (count_q >= last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (!run || clr || tick) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end

    AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> count_q == '0); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count_q == '0); // R9

endmodule

// File: rtl/esc_wdog_fsm.sv
module esc_wdog_fsm
    import esc_wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              en,
    input  logic                              tick,
    input  logic                              feed,
    input  logic [NUM_STAGES-1:0][1:0]        act,
    input  logic [NUM_STAGES-1:0][CNT_W-1:0]  hold,
    output logic                              fire_irq,
    output logic                              fire_cpu,
    output logic                              fire_sys
);

    stage_e           state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic [CNT_W:0]   cnt_inc;
    logic [1:0]       idx;
    logic             expire;
    act_e             cur_act;

    always_comb begin
        unique case (state_q)
            ST_STAGE1: idx = 2'd1;
            ST_STAGE2: idx = 2'd2;
            ST_STAGE3: idx = 2'd3;
            default:   idx = 2'd0;
        endcase
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        expire  = en && tick && !feed && (cnt_inc >= {1'b0, hold[idx]});
        cur_act = act_e'(act[idx]);
    end

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        if (!en) begin
            state_n = ST_IDLE;
            cnt_n   = '0;
        end else if (feed) begin
            state_n = ST_STAGE0;
            cnt_n   = '0;
        end else if (expire) begin
            cnt_n = '0;
            unique case (state_q)
                ST_IDLE, ST_STAGE0: state_n = ST_STAGE1;
                ST_STAGE1:          state_n = ST_STAGE2;
                ST_STAGE2:          state_n = ST_STAGE3;
                ST_STAGE3:          state_n = ST_STAGE0;
                default:            state_n = ST_IDLE;
            endcase
        end else begin
            if (tick) begin
                cnt_n = cnt_inc[CNT_W-1:0];
            end
            if (state_q == ST_IDLE) begin
                state_n = ST_STAGE0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        fire_irq = 1'b0;
        fire_cpu = 1'b0;
        fire_sys = 1'b0;
        if (expire) begin
            unique case (cur_act)
                ACT_IRQ:     fire_irq = 1'b1;
                ACT_CPU_RST: fire_cpu = 1'b1;
                ACT_SYS_RST: fire_sys = 1'b1;
                default:     ;
            endcase
        end
    end

    AST_FEED_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        en && feed |=> state_q == ST_STAGE0 && cnt_q == '0); // R7
    AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        expire && state_q == ST_STAGE3 |=> state_q == ST_STAGE0); // R6
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == ST_IDLE); // R3
    AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        expire && state_q == ST_STAGE1 |=> state_q == ST_STAGE2); // R5

endmodule

// File: rtl/esc_wdog_pulse.sv
module esc_wdog_pulse
    import esc_wdog_pkg::*;
#(
    parameter int CLKS_PER_UNIT = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trig,
    input  logic [2:0] len_code,
    output logic       pulse
);

    localparam int MAX_CLKS = 32 * CLKS_PER_UNIT;
    localparam int PW = $clog2(MAX_CLKS + 1);

    logic [PW-1:0] left_q;
    logic [PW-1:0] load_val;

    assign load_val = PW'(len_units(len_code)) * PW'(CLKS_PER_UNIT);
    assign pulse    = (left_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (trig) begin
            left_q <= load_val;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> pulse); // R8
    AST_PULSE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
        !trig && pulse |=> left_q == $past(left_q) - 1'b1); // R8

endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
    import esc_wdog_pkg::*;
#(
    parameter int CNT_W         = 32,
    parameter int DIV_W         = 16,
    parameter int CLKS_PER_UNIT = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic        irq_o,
    output logic        cpu_rst_o,
    output logic        sys_rst_o
);

    wdog_cfg_t                        cfg;
    logic [NUM_STAGES-1:0][CNT_W-1:0] hold;
    logic [DIV_W-1:0]                 div;
    logic                             presc_clr, feed, tick;
    logic                             int_raw, int_ena;
    logic                             fire_irq, fire_cpu, fire_sys;
    logic [1:0]                       trig;
    logic [1:0][2:0]                  len;
    logic [1:0]                       pulses;

    esc_wdog_regs #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_set(fire_irq), .act_cfg(cfg),
        .act_hold(hold), .div(div), .presc_clr(presc_clr), .feed(feed),
        .int_raw(int_raw), .int_ena(int_ena)
    );

    esc_wdog_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(cfg.en), .clr(presc_clr | feed),
        .div(div), .tick(tick)
    );

    esc_wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(cfg.en), .tick(tick), .feed(feed),
        .act(cfg.act), .hold(hold), .fire_irq(fire_irq), .fire_cpu(fire_cpu),
        .fire_sys(fire_sys)
    );

    assign trig = {fire_sys, fire_cpu};
    assign len  = {cfg.sys_len, cfg.cpu_len};

    for (genvar g = 0; g < 2; g++) begin : g_pulse
        esc_wdog_pulse #(.CLKS_PER_UNIT(CLKS_PER_UNIT)) u_pulse (
            .clk(clk), .rst_n(rst_n), .trig(trig[g]), .len_code(len[g]),
            .pulse(pulses[g])
        );
    end

    assign cpu_rst_o = pulses[0];
    assign sys_rst_o = pulses[1];
    assign irq_o     = int_raw & int_ena;

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        fire_irq && int_ena |=> irq_o); // R10

endmodule

// File: tb/esc_watchdog_test.sv
module esc_watchdog_test;

    localparam int CPU_UNIT = 2;
    localparam logic [31:0] KEY = 32'h50D8_3AA1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_o, cpu_rst_o, sys_rst_o;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    esc_watchdog #(.CLKS_PER_UNIT(CPU_UNIT)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o), .cpu_rst_o(cpu_rst_o),
        .sys_rst_o(sys_rst_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (n < 300) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (irq_o) break;
        end
    endtask

    function automatic logic [31:0] ctrl(input bit en, input logic [1:0] a0, a1, a2, a3,
                                         input logic [2:0] cl, sl, input bit upd);
        return {16'd0, upd, sl, cl, a3, a2, a1, a0, en};
    endfunction

    task automatic cleanup();
        wr(4'd0, ctrl(0, 0, 0, 0, 0, 1, 1, 1));
        wr(4'd9, 32'd1);
        wr(4'd1, 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d); chk("R1 ctrl", d, 32'h1200);
        rd(4'd2, d); chk("R1 hold0", d, 32'd26000000);
        rd(4'd3, d); chk("R1 hold1", d, 32'h07FF_FFFF);
        rd(4'd4, d); chk("R1 hold2", d, 32'h000F_FFFF);
        rd(4'd5, d); chk("R1 hold3", d, 32'h000F_FFFF);
        rd(4'd1, d); chk("R1 prescaler", d, 32'd1);
        rd(4'd7, d); chk("R1 key", d, KEY);
        chk("R1 outputs", {29'd0, irq_o, cpu_rst_o, sys_rst_o}, 32'd0);
    endtask

    task automatic t_lock();
        logic [31:0] d;
        wr(4'd8, 32'd1);
        wr(4'd7, 32'd0);
        rd(4'd7, d); chk("R2 key readback", d, 32'd0);
        wr(4'd2, 32'd5);
        rd(4'd2, d); chk("R2 locked hold", d, 32'd26000000);
        wr(4'd0, ctrl(1, 1, 0, 0, 0, 1, 1, 1));
        rd(4'd0, d); chk("R2 locked ctrl", d, 32'h1200);
        repeat (10) @(posedge clk);
        @(negedge clk); chk("R2 no irq while locked", {31'd0, irq_o}, 32'd0);
        wr(4'd7, KEY);
        wr(4'd2, 32'd5);
        rd(4'd2, d); chk("R2 unlocked hold", d, 32'd5);
    endtask

    task automatic t_update();
        logic [31:0] d;
        int n;
        wr(4'd2, 32'd2);
        wr(4'd0, ctrl(1, 1, 0, 0, 0, 1, 1, 0));
        repeat (10) @(posedge clk);
        @(negedge clk); chk("R3 staged no effect", {31'd0, irq_o}, 32'd0);
        rd(4'd0, d); chk("R3 staged readback", d, 32'h1203);
        wr(4'd0, ctrl(1, 1, 0, 0, 0, 1, 1, 1));
        wait_irq(n); chk("R3 applied irq edge", 32'(n), 32'd2);
        cleanup();
    endtask

    task automatic t_presc();
        int n;
        wr(4'd1, 32'd3);
        wr(4'd2, 32'd2);
        wr(4'd0, ctrl(1, 1, 0, 0, 0, 1, 1, 1));
        wait_irq(n); chk("R4 div3 hold2 edge", 32'(n), 32'd6);
        cleanup();
    endtask

    task automatic t_pclr();
        int n;
        wr(4'd1, 32'd4);
        wr(4'd2, 32'd1);
        wr(4'd0, ctrl(1, 1, 0, 0, 0, 1, 1, 1));
        wr(4'd1, 32'h8000_0004);
        wait_irq(n); chk("R9 prescaler clear", 32'(n), 32'd4);
        cleanup();
    endtask

    task automatic t_feed();
        int n;
        wr(4'd2, 32'd5);
        wr(4'd0, ctrl(1, 1, 0, 0, 0, 1, 1, 1));
        repeat (3) @(posedge clk);
        wr(4'd6, 32'd0);
        wait_irq(n); chk("R7 feed restart", 32'(n), 32'd5);
        cleanup();
    endtask

    task automatic t_escalate();
        logic [20:0] ir, cr, sr;
        wr(4'd2, 32'd3);
        wr(4'd3, 32'd2);
        wr(4'd4, 32'd1);
        wr(4'd5, 32'd2);
        wr(4'd0, ctrl(1, 0, 1, 2, 3, 1, 2, 1));
        for (int i = 1; i <= 20; i++) begin
            @(posedge clk);
            @(negedge clk);
            ir[i] = irq_o; cr[i] = cpu_rst_o; sr[i] = sys_rst_o;
        end
        chk("R5 stage0 action none", {31'd0, ir[4]}, 32'd0);
        chk("R5 stage1 irq", {31'd0, ir[5]}, 32'd1);
        chk("R5 cpu before", {31'd0, cr[5]}, 32'd0);
        chk("R5 stage2 cpu", {31'd0, cr[6]}, 32'd1);
        chk("R8 cpu width end", {30'd0, cr[9], cr[10]}, 32'b10);
        chk("R5 stage3 sys", {30'd0, sr[7], sr[8]}, 32'b01);
        chk("R8 sys width end", {30'd0, sr[13], sr[14]}, 32'b10);
        chk("R6 wrap cpu again", {30'd0, cr[13], cr[14]}, 32'b01);
        chk("R6 wrap sys again", {30'd0, sr[15], sr[16]}, 32'b01);
        wr(4'd0, ctrl(0, 0, 0, 0, 0, 1, 1, 1));
    endtask

    task automatic t_irq();
        logic [31:0] d;
        chk("R10 irq held", {31'd0, irq_o}, 32'd1);
        rd(4'd9, d); chk("R10 raw set", d, 32'd1);
        wr(4'd8, 32'd0);
        @(negedge clk); chk("R10 masked", {31'd0, irq_o}, 32'd0);
        rd(4'd10, d); chk("R10 status masked", d, 32'd0);
        wr(4'd9, 32'd0);
        rd(4'd9, d); chk("R10 zero write keeps raw", d, 32'd1);
        wr(4'd8, 32'd1);
        rd(4'd10, d); chk("R10 status unmasked", d, 32'd1);
        wr(4'd9, 32'd1);
        rd(4'd9, d); chk("R10 raw cleared", d, 32'd0);
        @(negedge clk); chk("R10 irq low", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_lock();
        t_update();
        t_presc();
        t_pclr();
        t_feed();
        t_escalate();
        t_irq();
        finish_run();
    end

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule